// File: doc/BRIEF.md
# Scrambler Auto-Synchronization Controller

This block carries a self-synchronizing 23-stage scrambler/descrambler that works on received sign and magnitude decisions, together with a controller that acquires scrambler lock without software help. Each valid symbol steps the shift register once per processed bit. The register is driven by the feedback polynomial x^23 + x^18 + 1. With auto-lock off, the descrambler-enable input chooses between descrambling and scrambling the received bits.

With auto-lock on, the controller ignores the descrambler-enable input. It first descrambles for 23 bit updates so that the register fills with received bits. It then lets the register free-run on a constant-ones input for a window of up to 128 updates. In that window it counts how often the locally generated bit equals the received decision. When the count rises strictly above a programmed 8-bit threshold, a sticky sync flag is raised and the register stays in the ones mode. If the window runs out first, training starts over.

A two-level mode halves the update rate. Only the sign bit of each symbol is used, and the magnitude output is held at zero.

Top module: `scr_sync_acq`

## Requirements
- R1: With auto-lock off and `descr_en`=1, each processed bit gives output = rx XOR stage18 XOR stage23. The received bit is shifted into the register. Stage k is the bit processed k updates earlier, and the register is zero after reset.
- R2: With auto-lock off and `descr_en`=0, each processed bit gives output = rx XOR stage18 XOR stage23, and the output bit is shifted into the register.
- R3: In four-level mode (`two_level`=0), a symbol with `dec_valid`=1 makes two updates: the sign bit first, then the magnitude bit. The resulting bits appear on `scr_sign` and `scr_mag` at the next clock edge, with `scr_valid`=1 for that one cycle.
- R4: In two-level mode, a symbol makes one update on the sign bit only. `dec_mag` is ignored and `scr_mag` is 0.
- R5: With auto-lock on, `descr_en` has no effect. The first 23 updates after auto-lock is enabled (or after retraining starts) descramble as in R1.
- R6: After training, each update runs in ones mode: output = NOT(stage18 XOR stage23), and the output is shifted into the register. Each output equal to the received bit increments an agreement count. When the count becomes greater than `sync_thresh`, `sync_flag` is set at that symbol's clock edge and the sequence ends.
- R7: After lock, with auto-lock still on, every update stays in ones mode whatever the received bits are.
- R8: If 128 check updates pass without the count exceeding the threshold, the next update starts a new 23-update training phase with the count at zero.
- R9: `sync_flag` is sticky and is cleared only by `sync_clr`. A lock in the same cycle as `sync_clr` leaves the flag set.
- R10: Clearing `autolock_en` returns the controller to idle, where R1/R2 apply. Setting it again restarts training.
- R11: After reset, `scr_valid`, `scr_sign`, `scr_mag` and `sync_flag` are 0.
- R12: While `dec_valid`=0, the register does not move, `scr_valid` is 0, and `scr_sign`/`scr_mag` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Received symbol decision valid |
| dec_sign | input | 1 | Received sign decision bit |
| dec_mag | input | 1 | Received magnitude decision bit |
| descr_en | input | 1 | 1 = descramble, 0 = scramble (auto-lock off) |
| autolock_en | input | 1 | Enables the automatic acquisition sequence |
| two_level | input | 1 | 1 = sign-only symbol-rate updates |
| sync_thresh | input | 8 | Agreement threshold (lock when count > value) |
| sync_clr | input | 1 | Clears the sticky sync flag |
| scr_valid | output | 1 | Output bits valid |
| scr_sign | output | 1 | Generated sign-position bit |
| scr_mag | output | 1 | Generated magnitude-position bit |
| sync_flag | output | 1 | Sticky lock indication |

## Verification
The hardest case to reach is a check window that runs to its end without locking and then retrains. Random decisions agree about half the time, so they either lock by chance or never reach a clean window end. The bench therefore holds a shift-register model of its own and uses it to feed, in two-level mode, the exact complement of each prediction for all 128 check updates. This drives the count to zero. The bench then switches to a freshly seeded scrambled-ones stream and checks that the flag rises on the symbol number given by 23 + 128 + 23 + threshold + 1. Four-level lock symbols are checked in the same way, as ceil((24 + threshold) / 2), over a threshold sweep that includes 0 and 127.

// File: rtl/scr_sync_acq_pkg.sv
package scr_sync_acq_pkg;

    // acquisition controller states
    typedef enum logic [1:0] {
        ACQ_IDLE   = 2'd0,
        ACQ_TRAIN  = 2'd1,
        ACQ_CHECK  = 2'd2,
        ACQ_LOCKED = 2'd3
    } acq_mode_e;

    // per-bit operation of the shift register
    typedef enum logic [1:0] {
        OP_DESCR = 2'd0,
        OP_SCRAM = 2'd1,
        OP_ONES  = 2'd2
    } lfsr_op_e;

    localparam int DEF_LFSR_LEN  = 23;
    localparam int DEF_TAP_NEAR  = 18;
    localparam int DEF_TRAIN_UPD = 23;
    localparam int DEF_CHECK_UPD = 128;
    localparam int DEF_THR_W     = 8;

    // which register operation a controller state implies
    function automatic lfsr_op_e pick_op(acq_mode_e mode, logic descr_en);
        lfsr_op_e op;
        case (mode)
            ACQ_IDLE:  op = descr_en ? OP_DESCR : OP_SCRAM;
            ACQ_TRAIN: op = OP_DESCR;
            default:   op = OP_ONES;
        endcase
        return op;
    endfunction

    // data bit presented to the feedback sum
    function automatic logic op_data(lfsr_op_e op, logic rx_bit);
        return (op == OP_ONES) ? 1'b1 : rx_bit;
    endfunction

    // bit shifted into the register: received bit for descrambling,
    // generated bit otherwise
    function automatic logic op_shift_in(lfsr_op_e op, logic rx_bit, logic gen_bit);
        return (op == OP_DESCR) ? rx_bit : gen_bit;
    endfunction

endpackage

// File: rtl/scr_sync_entry.sv
module scr_sync_entry
    import scr_sync_acq_pkg::*;
#(
    parameter int PH_W = 7,
    parameter int AG_W = 8
) (
    input  logic            autolock_en,
    input  acq_mode_e       mode_q,
    input  logic [PH_W-1:0] ph_q,
    input  logic [AG_W-1:0] ag_q,
    output acq_mode_e       mode_s,
    output logic [PH_W-1:0] ph_s,
    output logic [AG_W-1:0] ag_s
);
    // maps the stored state onto the state the lanes start from
    always_comb begin
        mode_s = mode_q;
        ph_s   = ph_q;
        ag_s   = ag_q;
        if (!autolock_en) begin
            mode_s = ACQ_IDLE;
            ph_s   = '0;
            ag_s   = '0;
        end else if (mode_q == ACQ_IDLE) begin
            mode_s = ACQ_TRAIN;
            ph_s   = '0;
            ag_s   = '0;
        end
    end
endmodule

// File: rtl/scr_sync_lane.sv
module scr_sync_lane
    import scr_sync_acq_pkg::*;
#(
    parameter int LFSR_LEN  = DEF_LFSR_LEN,
    parameter int TAP_NEAR  = DEF_TAP_NEAR,
    parameter int TRAIN_UPD = DEF_TRAIN_UPD,
    parameter int CHECK_UPD = DEF_CHECK_UPD,
    parameter int THR_W     = DEF_THR_W,
    parameter int PH_W      = 7,
    parameter int AG_W      = 8
) (
    input  logic                en,
    input  logic                rx_bit,
    input  logic                descr_en,
    input  logic [THR_W-1:0]    thresh,
    input  logic [LFSR_LEN-1:0] lfsr_i,
    input  acq_mode_e           mode_i,
    input  logic [PH_W-1:0]     ph_i,
    input  logic [AG_W-1:0]     ag_i,
    output logic [LFSR_LEN-1:0] lfsr_o,
    output acq_mode_e           mode_o,
    output logic [PH_W-1:0]     ph_o,
    output logic [AG_W-1:0]     ag_o,
    output logic                gen_bit,
    output logic                lock_evt
);
    localparam int CMP_W = (THR_W > AG_W) ? THR_W : AG_W;

    lfsr_op_e        op;
    logic            tap_x;
    logic            shin;
    logic [AG_W-1:0] ag_nx;

    always_comb begin
        op       = pick_op(mode_i, descr_en);
        tap_x    = lfsr_i[TAP_NEAR-1] ^ lfsr_i[LFSR_LEN-1];
        lfsr_o   = lfsr_i;
        mode_o   = mode_i;
        ph_o     = ph_i;
        ag_o     = ag_i;
        gen_bit  = 1'b0;
        lock_evt = 1'b0;
        shin     = 1'b0;
        ag_nx    = ag_i;
        if (en) begin
            gen_bit = op_data(op, rx_bit) ^ tap_x;
            shin    = op_shift_in(op, rx_bit, gen_bit);
            lfsr_o  = {lfsr_i[LFSR_LEN-2:0], shin};
            case (mode_i)
                ACQ_TRAIN: begin
                    if (ph_i == PH_W'(TRAIN_UPD - 1)) begin
                        mode_o = ACQ_CHECK;
                        ph_o   = '0;
                        ag_o   = '0;
                    end else begin
                        ph_o = ph_i + 1'b1;
                    end
                end
                ACQ_CHECK: begin
                    ag_nx = ag_i + AG_W'(gen_bit == rx_bit);
                    if (CMP_W'(ag_nx) > CMP_W'(thresh)) begin
                        mode_o   = ACQ_LOCKED;
                        ag_o     = ag_nx;
                        lock_evt = 1'b1;
                    end else if (ph_i == PH_W'(CHECK_UPD - 1)) begin
                        mode_o = ACQ_TRAIN;
                        ph_o   = '0;
                        ag_o   = '0;
                    end else begin
                        ph_o = ph_i + 1'b1;
                        ag_o = ag_nx;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scr_sync_flag.sv
module scr_sync_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end
endmodule

// File: rtl/scr_sync_acq.sv
module scr_sync_acq
    import scr_sync_acq_pkg::*;
#(
    parameter int LFSR_LEN  = DEF_LFSR_LEN,
    parameter int TAP_NEAR  = DEF_TAP_NEAR,
    parameter int TRAIN_UPD = DEF_TRAIN_UPD,
    parameter int CHECK_UPD = DEF_CHECK_UPD,
    parameter int THR_W     = DEF_THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic             dec_sign,
    input  logic             dec_mag,
    input  logic             descr_en,
    input  logic             autolock_en,
    input  logic             two_level,
    input  logic [THR_W-1:0] sync_thresh,
    input  logic             sync_clr,
    output logic             scr_valid,
    output logic             scr_sign,
    output logic             scr_mag,
    output logic             sync_flag
);
    localparam int NUM_LANES = 2;
    localparam int PH_MAX    = (TRAIN_UPD > CHECK_UPD) ? TRAIN_UPD : CHECK_UPD;
    localparam int PH_W      = $clog2(PH_MAX);
    localparam int AG_W      = $clog2(CHECK_UPD + 1);

    logic [LFSR_LEN-1:0] lfsr_q;
    acq_mode_e           mode_q;
    logic [PH_W-1:0]     ph_q;
    logic [AG_W-1:0]     ag_q;

    acq_mode_e           mode_s;
    logic [PH_W-1:0]     ph_s;
    logic [AG_W-1:0]     ag_s;

    logic [LFSR_LEN-1:0] lfsr_c [0:NUM_LANES];
    acq_mode_e           mode_c [0:NUM_LANES];
    logic [PH_W-1:0]     ph_c   [0:NUM_LANES];
    logic [AG_W-1:0]     ag_c   [0:NUM_LANES];

    logic [NUM_LANES-1:0] rx_v;
    logic [NUM_LANES-1:0] en_v;
    logic [NUM_LANES-1:0] gen_v;
    logic [NUM_LANES-1:0] lock_v;
    logic                 lock_any;

    scr_sync_entry #(
        .PH_W (PH_W),
        .AG_W (AG_W)
    ) u_entry (
        .autolock_en (autolock_en),
        .mode_q      (mode_q),
        .ph_q        (ph_q),
        .ag_q        (ag_q),
        .mode_s      (mode_s),
        .ph_s        (ph_s),
        .ag_s        (ag_s)
    );

    // lane 0 handles the sign bit, lane 1 the magnitude bit; lane 1 is
    // idle in two-level mode, which also forces its output bit to zero
    assign rx_v = {dec_mag, dec_sign};
    assign en_v = {dec_valid & ~two_level, dec_valid};

    assign lfsr_c[0] = lfsr_q;
    assign mode_c[0] = mode_s;
    assign ph_c[0]   = ph_s;
    assign ag_c[0]   = ag_s;

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        scr_sync_lane #(
            .LFSR_LEN  (LFSR_LEN),
            .TAP_NEAR  (TAP_NEAR),
            .TRAIN_UPD (TRAIN_UPD),
            .CHECK_UPD (CHECK_UPD),
            .THR_W     (THR_W),
            .PH_W      (PH_W),
            .AG_W      (AG_W)
        ) u_lane (
            .en       (en_v[gi]),
            .rx_bit   (rx_v[gi]),
            .descr_en (descr_en),
            .thresh   (sync_thresh),
            .lfsr_i   (lfsr_c[gi]),
            .mode_i   (mode_c[gi]),
            .ph_i     (ph_c[gi]),
            .ag_i     (ag_c[gi]),
            .lfsr_o   (lfsr_c[gi+1]),
            .mode_o   (mode_c[gi+1]),
            .ph_o     (ph_c[gi+1]),
            .ag_o     (ag_c[gi+1]),
            .gen_bit  (gen_v[gi]),
            .lock_evt (lock_v[gi])
        );
    end

    assign lock_any = |lock_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q    <= '0;
            mode_q    <= ACQ_IDLE;
            ph_q      <= '0;
            ag_q      <= '0;
            scr_valid <= 1'b0;
            scr_sign  <= 1'b0;
            scr_mag   <= 1'b0;
        end else begin
            lfsr_q    <= lfsr_c[NUM_LANES];
            mode_q    <= mode_c[NUM_LANES];
            ph_q      <= ph_c[NUM_LANES];
            ag_q      <= ag_c[NUM_LANES];
            scr_valid <= dec_valid;
            if (dec_valid) begin
                scr_sign <= gen_v[0];
                scr_mag  <= gen_v[1];
            end
        end
    end

    scr_sync_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (lock_any),
        .clr_req (sync_clr),
        .flag    (sync_flag)
    );
endmodule

// File: rtl/scr_sync_acq_chk.sv
module scr_sync_acq_chk
    import scr_sync_acq_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      dec_valid,
    input logic      two_level,
    input logic      autolock_en,
    input logic      sync_clr,
    input logic      scr_valid,
    input logic      scr_sign,
    input logic      scr_mag,
    input logic      sync_flag,
    input logic      lock_any,
    input acq_mode_e mode_q
);
    p_valid_follow_r3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> scr_valid);

    p_mag_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && two_level) |=> !scr_mag);

    p_flag_rise_locked_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_flag) |-> (mode_q == ACQ_LOCKED));

    p_lock_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ACQ_LOCKED && autolock_en) |=> (mode_q == ACQ_LOCKED));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (sync_flag && !sync_clr) |=> sync_flag);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (sync_clr && !lock_any) |=> !sync_flag);

    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !autolock_en |=> (mode_q == ACQ_IDLE));

    p_hold_no_valid_r12: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> (!scr_valid && $stable(scr_sign) && $stable(scr_mag)));
endmodule

bind scr_sync_acq scr_sync_acq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .two_level   (two_level),
    .autolock_en (autolock_en),
    .sync_clr    (sync_clr),
    .scr_valid   (scr_valid),
    .scr_sign    (scr_sign),
    .scr_mag     (scr_mag),
    .sync_flag   (sync_flag),
    .lock_any    (lock_any),
    .mode_q      (mode_q)
);

// File: tb/scr_sync_acq_tb.sv
`timescale 1ns/1ps
module scr_sync_acq_tb;
    localparam int TRAIN_N = 23;
    localparam int CHECK_N = 128;

    logic       clk = 1'b0;
    logic       rst;
    logic       dec_valid, dec_sign, dec_mag;
    logic       descr_en, autolock_en, two_level, sync_clr;
    logic [7:0] sync_thresh;
    logic       scr_valid, scr_sign, scr_mag, sync_flag;

    always #2 clk = ~clk;

    scr_sync_acq u_dut (
        .clk         (clk),
        .rst         (rst),
        .dec_valid   (dec_valid),
        .dec_sign    (dec_sign),
        .dec_mag     (dec_mag),
        .descr_en    (descr_en),
        .autolock_en (autolock_en),
        .two_level   (two_level),
        .sync_thresh (sync_thresh),
        .sync_clr    (sync_clr),
        .scr_valid   (scr_valid),
        .scr_sign    (scr_sign),
        .scr_mag     (scr_mag),
        .sync_flag   (sync_flag)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    // history of shifted-in bits, newest at the back
    bit mh[$];
    int mmode;   // 0 idle, 1 train, 2 check, 3 locked
    int mph;
    int magree;
    bit mflag;
    bit c_den, c_al, c_two;
    bit [7:0] c_thr;

    function automatic bit mtap();
        return mh[mh.size()-18] ^ mh[mh.size()-23];
    endfunction

    task automatic mreset();
        mh.delete();
        for (int i = 0; i < 23; i++) mh.push_back(1'b0);
        mmode = 0; mph = 0; magree = 0; mflag = 0;
    endtask

    task automatic mbit(input bit rx, output bit g, output bit lk);
        bit t;
        int op;
        t  = mtap();
        lk = 0;
        if (mmode == 0)      op = c_den ? 0 : 1;
        else if (mmode == 1) op = 0;
        else                 op = 2;
        if (op == 0)      begin g = rx ^ t; mh.push_back(rx); end
        else if (op == 1) begin g = rx ^ t; mh.push_back(g);  end
        else              begin g = !t;     mh.push_back(g);  end
        if (mh.size() > 40) void'(mh.pop_front());
        if (mmode == 1) begin
            if (mph == TRAIN_N - 1) begin mmode = 2; mph = 0; magree = 0; end
            else mph++;
        end else if (mmode == 2) begin
            if (g == rx) magree++;
            if (magree > int'(c_thr)) begin mmode = 3; lk = 1; end
            else if (mph == CHECK_N - 1) begin mmode = 1; mph = 0; magree = 0; end
            else mph++;
        end
    endtask

    // transmit-side scrambled-ones generator, separate history
    bit th[$];
    task automatic tx_seed();
        th.delete();
        for (int i = 0; i < 23; i++) th.push_back(1'($urandom_range(0, 1)));
    endtask
    function automatic bit tx_next();
        bit c;
        c = 1'b1 ^ th[th.size()-18] ^ th[th.size()-23];
        th.push_back(c);
        if (th.size() > 40) void'(th.pop_front());
        return c;
    endfunction

    // ---------------- stimulus tasks ----------------
    task automatic set_ctrl(input bit den, input bit al, input bit two, input bit [7:0] thr);
        @(negedge clk);
        descr_en = den; autolock_en = al; two_level = two; sync_thresh = thr;
        c_den = den; c_al = al; c_two = two; c_thr = thr;
        if (!al) begin mmode = 0; mph = 0; magree = 0; end
        else if (mmode == 0) begin mmode = 1; mph = 0; magree = 0; end
        @(negedge clk);
    endtask

    task automatic sym(input bit s, input bit m, input bit clr, input string tag);
        bit g0, g1, l0, l1;
        @(negedge clk);
        dec_valid = 1; dec_sign = s; dec_mag = m; sync_clr = clr;
        mbit(s, g0, l0);
        if (!c_two) mbit(m, g1, l1);
        else begin g1 = 0; l1 = 0; end
        if (l0 || l1) mflag = 1;
        else if (clr) mflag = 0;
        @(negedge clk);
        dec_valid = 0; sync_clr = 0;
        dec_sign = 1'($urandom_range(0, 1)); dec_mag = 1'($urandom_range(0, 1));
        chk(tag, "scr_valid", 32'(scr_valid), 32'd1);
        chk(tag, "scr_sign",  32'(scr_sign),  32'(g0));
        chk(tag, "scr_mag",   32'(scr_mag),   32'(g1));
        chk(tag, "sync_flag", 32'(sync_flag), 32'(mflag));
    endtask

    // cycles with no valid symbol: outputs must hold (R12)
    task automatic gap(input int n);
        logic s0, m0;
        s0 = scr_sign; m0 = scr_mag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dec_sign = 1'($urandom_range(0, 1)); dec_mag = 1'($urandom_range(0, 1));
            chk("R12", "scr_valid", 32'(scr_valid), 32'd0);
            chk("R12", "scr_sign hold", 32'(scr_sign), 32'(s0));
            chk("R12", "scr_mag hold",  32'(scr_mag),  32'(m0));
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        sync_clr = 1; mflag = 0;
        @(negedge clk);
        sync_clr = 0;
        chk("R9", "flag cleared", 32'(sync_flag), 32'd0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int thr_list[6];
        int ls;
        rst = 1; dec_valid = 0; dec_sign = 0; dec_mag = 0;
        descr_en = 0; autolock_en = 0; two_level = 0; sync_clr = 0; sync_thresh = 0;
        c_den = 0; c_al = 0; c_two = 0; c_thr = 0;
        mreset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11", "scr_valid", 32'(scr_valid), 32'd0);
        chk("R11", "scr_sign",  32'(scr_sign),  32'd0);
        chk("R11", "scr_mag",   32'(scr_mag),   32'd0);
        chk("R11", "sync_flag", 32'(sync_flag), 32'd0);

        // R1: plain descrambling, four-level (R3)
        set_ctrl(1, 0, 0, 0);
        for (int i = 0; i < 150; i++)
            sym(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R1");
        // R2: plain scrambling
        set_ctrl(0, 0, 0, 0);
        for (int i = 0; i < 150; i++)
            sym(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R2");
        // R4: two-level, both directions
        set_ctrl(1, 0, 1, 0);
        for (int i = 0; i < 60; i++)
            sym(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R4");
        set_ctrl(0, 0, 1, 0);
        for (int i = 0; i < 60; i++)
            sym(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R4");
        // R12: gaps between symbols, register must not move
        set_ctrl(1, 0, 0, 0);
        for (int i = 0; i < 20; i++) begin
            sym(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R12");
            gap(3);
        end

        // R5/R6/R7: threshold sweep, four-level, descr_en low (overridden)
        thr_list = '{0, 1, 7, 40, 99, 127};
        foreach (thr_list[t]) begin
            set_ctrl(0, 0, 0, 8'(thr_list[t]));
            pulse_clr();
            set_ctrl(0, 1, 0, 8'(thr_list[t]));
            tx_seed();
            ls = (24 + thr_list[t] + 1) / 2;
            for (int k = 1; k <= ls + 5; k++) begin
                bit a, b;
                a = tx_next(); b = tx_next();
                sym(a, b, 0, "R5");
                chk("R6", "lock symbol", 32'(sync_flag), 32'(k >= ls));
            end
            for (int k = 0; k < 30; k++)
                sym(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R7");
        end

        // R9: clear requested every symbol; lock must still win
        set_ctrl(1, 0, 0, 10);
        pulse_clr();
        set_ctrl(1, 1, 0, 10);
        tx_seed();
        for (int k = 1; k <= 20; k++) begin
            bit a, b;
            a = tx_next(); b = tx_next();
            sym(a, b, 1, "R9");
            chk("R9", "set over clear", 32'(sync_flag), 32'(k == 17));
        end

        // R8: two-level, window of pure disagreement then retrain
        set_ctrl(1, 0, 1, 30);
        pulse_clr();
        set_ctrl(1, 1, 1, 30);
        for (int k = 1; k <= TRAIN_N; k++) sym(1'($urandom_range(0, 1)), 0, 0, "R8");
        for (int k = 1; k <= CHECK_N; k++) begin
            sym(mtap(), 1'($urandom_range(0, 1)), 0, "R8");
            chk("R8", "no lock in failed window", 32'(sync_flag), 32'd0);
        end
        tx_seed();
        for (int k = 1; k <= TRAIN_N + 31 + 3; k++) begin
            sym(tx_next(), 1'($urandom_range(0, 1)), 0, "R8");
            chk("R8", "lock after retrain", 32'(sync_flag), 32'(k >= TRAIN_N + 31));
        end

        // R10: auto-lock off returns to plain descrambling
        set_ctrl(1, 0, 0, 5);
        pulse_clr();
        for (int k = 0; k < 50; k++)
            sym(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R10");
        // re-enable: training restarts from the first update
        set_ctrl(1, 1, 0, 5);
        tx_seed();
        for (int k = 1; k <= 20; k++) begin
            bit a, b;
            a = tx_next(); b = tx_next();
            sym(a, b, 0, "R10");
            chk("R10", "relock symbol", 32'(sync_flag), 32'(k >= 15));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule